// File: doc/BRIEF.md
# Overcurrent Hiccup Restart Sequencer

This block sequences the start-up of a switching converter and decides when it may switch after a fault. When enable rises, it requests a soft-start with a one-clock pulse. It then waits for the soft-start ramp to report completion, and after that it marks the converter as running. An overcurrent flag seen during soft-start or running puts every power switch into the off state. The sequencer then holds that state for a fixed number of switching cycles, counted on a per-cycle tick input, and tries a fresh soft-start. If the fault is still there on retry, the trip-and-wait loop repeats with no limit.

A separate open-sense-line flag forces a shutdown that lasts as long as the flag is high. When the flag falls, the sequencer restarts from the beginning of soft-start. Dropping enable returns the block to idle from any state, with all switches off. Comparators, current sensing and the ramp generator are outside this block; their results arrive as synchronous digital flags.

Top module: `ocp_retry_seq`

## Requirements
- R1: While reset is low and on the first clock after it is released, state_o is 0 (idle), gates_off_o is 1, and ss_start_o and running_o are 0.
- R2: state_o encodes idle=0, soft-start=1, run=2, overcurrent wait=3 and open-sense shutdown=4. gates_off_o is 1 in states 0, 3 and 4 and 0 in states 1 and 2. running_o is 1 only in state 2.
- R3: From idle with enable high, the next clock edge enters soft-start. ss_start_o is 1 for exactly one clock, the first clock in which state_o reads 1, on every entry to soft-start.
- R4: In soft-start with ss_done_i high, the next edge enters run, unless overcurrent, open-sense or a low enable takes precedence.
- R5: With enable high and open-sense low, oc_det_i high in soft-start or run moves the block to the overcurrent wait on the next edge, so gates_off_o rises one clock after the flag. Overcurrent wins over ss_done_i in the same cycle.
- R6: The overcurrent wait ends on the edge of the WAIT_CYCLES-th tick (default 4096) seen while state_o reads 3, and the block then enters soft-start. A tick in the cycle that causes the trip is not counted.
- R7: oc_det_i has no effect during the overcurrent wait. It neither restarts nor shortens the count.
- R8: If oc_det_i is still high when soft-start is re-entered after a wait, the block trips back into the overcurrent wait on the next edge, and it does so again on every retry.
- R9: With enable high, open_sense_i high moves the block from any state to state 4 on the next edge. This takes priority over overcurrent and over the last tick of a wait, and the block stays in state 4 while the flag is high.
- R10: In state 4, open_sense_i low moves the block to soft-start on the next edge, with the ss_start_o pulse.
- R11: enable low moves the block from any state to idle on the next edge and clears the wait count, so a later wait again lasts the full WAIT_CYCLES ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable |
| sw_tick_i | input | 1 | One-clock pulse per switching cycle |
| oc_det_i | input | 1 | Overcurrent detected |
| open_sense_i | input | 1 | Remote sense line open |
| ss_done_i | input | 1 | Soft-start ramp finished |
| ss_start_o | output | 1 | One-clock soft-start request |
| gates_off_o | output | 1 | Turn all upper and lower switches off |
| running_o | output | 1 | Converter in normal operation |
| state_o | output | 3 | Current sequencer state code |

## Verification
The events that most often coincide are the last tick of an overcurrent wait and a rising open-sense flag. Overcurrent and soft-start completion in the same soft-start cycle are a second such pair. The bench drives both pairs on the same clock and expects the higher-priority outcome: state 4 for the first pair and state 3 for the second. Around this, every one of the five states is reached and then given all 32 combinations of the five control inputs. The next state and outputs are compared against values derived from the priority order. Separate runs count wait ticks with irregular gaps and check that the exit lands on exactly the configured tick.

// File: rtl/ocp_retry_pkg.sv
// Shared state encoding for the hiccup restart sequencer.
// The numeric codes are visible on the state_o port.
package ocp_retry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SOFT   = 3'd1,
        ST_RUN    = 3'd2,
        ST_OCWAIT = 3'd3,
        ST_OPEN   = 3'd4
    } seq_state_e;
endpackage

// File: rtl/ocp_wait_timer.sv
// Counts switching-cycle ticks while the hiccup wait is active.
// It asserts done_o, combinationally, on the tick that completes
// WAIT_CYCLES ticks.
// Assumes run_i is low outside the wait, which clears the count.
module ocp_wait_timer #(
    parameter int WAIT_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Tick counter, held at zero whenever the wait is not active.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Wait completes on the tick that arrives when the count sits at its last value.
    always_comb begin
        done_o = run_i && tick_i && (cnt_q == LAST);
    end
endmodule

// File: rtl/ocp_retry_fsm.sv
// State machine for start-up, overcurrent hiccup and open-sense shutdown.
// The priority order is: enable low, then open-sense, then overcurrent,
// then soft-start done.
// Assumes all flags are synchronous to clk. Outputs are decoded from registers.
module ocp_retry_fsm
    import ocp_retry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       oc_det_i,
    input  logic       open_sense_i,
    input  logic       ss_done_i,
    input  logic       wait_done_i,
    output seq_state_e state_o,
    output logic       ss_start_o,
    output logic       gates_off_o,
    output logic       running_o
);
    seq_state_e state_q, state_d;
    logic       ss_q;

    // Next-state selection by fault priority.
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else if (open_sense_i) begin
            state_d = ST_OPEN;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_SOFT;
                ST_SOFT: begin
                    if (oc_det_i)       state_d = ST_OCWAIT;
                    else if (ss_done_i) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (oc_det_i)       state_d = ST_OCWAIT;
                end
                ST_OCWAIT: begin
                    if (wait_done_i)    state_d = ST_SOFT;
                end
                ST_OPEN:   state_d = ST_SOFT;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register and the soft-start request raised on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ss_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ss_q    <= (state_d == ST_SOFT) && (state_q != ST_SOFT);
        end
    end

    // Output decode from the registered state.
    always_comb begin
        state_o     = state_q;
        ss_start_o  = ss_q;
        running_o   = (state_q == ST_RUN);
        gates_off_o = (state_q == ST_IDLE) || (state_q == ST_OCWAIT) ||
                      (state_q == ST_OPEN);
    end
endmodule

// File: rtl/ocp_retry_seq.sv
// Top of the hiccup restart sequencer.
// It joins the state machine and the wait timer.
// The timer only runs while the state machine is in the overcurrent wait
// and enable is high.
module ocp_retry_seq
    import ocp_retry_pkg::*;
#(
    parameter int WAIT_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       sw_tick_i,
    input  logic       oc_det_i,
    input  logic       open_sense_i,
    input  logic       ss_done_i,
    output logic       ss_start_o,
    output logic       gates_off_o,
    output logic       running_o,
    output logic [2:0] state_o
);
    seq_state_e state_w;
    logic       wait_done_w;
    logic       wait_run_w;

    // Timer enable: overcurrent wait while enabled.
    always_comb begin
        wait_run_w = (state_w == ST_OCWAIT) && en_i;
    end

    ocp_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (wait_run_w),
        .tick_i (sw_tick_i),
        .done_o (wait_done_w)
    );

    ocp_retry_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .oc_det_i     (oc_det_i),
        .open_sense_i (open_sense_i),
        .ss_done_i    (ss_done_i),
        .wait_done_i  (wait_done_w),
        .state_o      (state_w),
        .ss_start_o   (ss_start_o),
        .gates_off_o  (gates_off_o),
        .running_o    (running_o)
    );

    // Publish the state code on the port.
    always_comb begin
        state_o = state_w;
    end
endmodule

// File: rtl/ocp_retry_chk.sv
// Property checker for the sequencer.
// It is bound to every instance of ocp_retry_seq.
// It keeps its own count of wait ticks instead of looking at the timer.
module ocp_retry_chk #(
    parameter int WAIT_CYCLES = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       sw_tick_i,
    input logic       oc_det_i,
    input logic       open_sense_i,
    input logic       ss_done_i,
    input logic       ss_start_o,
    input logic       gates_off_o,
    input logic       running_o,
    input logic [2:0] state_o
);
    localparam int TW = $clog2(WAIT_CYCLES + 1) + 1;
    localparam logic [TW-1:0] LAST = TW'(WAIT_CYCLES - 1);

    logic [TW-1:0] ticks_q;

    // Count ticks observed while the port reports the overcurrent wait.
    always_ff @(posedge clk) begin
        if (!rst_n || state_o != 3'd3) ticks_q <= '0;
        else if (sw_tick_i)            ticks_q <= ticks_q + 1'b1;
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);  // R2
    AST_RUN_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> !gates_off_o);  // R2
    AST_SS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start_o |=> !ss_start_o);  // R3
    AST_SS_IN_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start_o |-> state_o == 3'd1);  // R3
    AST_SOFT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && ss_done_i && en_i && !open_sense_i && !oc_det_i)
        |=> state_o == 3'd2);  // R4
    AST_OC_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd1 || state_o == 3'd2) && oc_det_i && en_i && !open_sense_i)
        |=> (state_o == 3'd3 && gates_off_o));  // R5
    AST_WAIT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && sw_tick_i && ticks_q == LAST && en_i && !open_sense_i)
        |=> (state_o == 3'd1 && ss_start_o));  // R6
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && !(sw_tick_i && ticks_q == LAST) && en_i && !open_sense_i)
        |=> state_o == 3'd3);  // R7
    AST_OPEN_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && open_sense_i) |=> (state_o == 3'd4 && gates_off_o));  // R9
    AST_OPEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && en_i && !open_sense_i) |=> (state_o == 3'd1 && ss_start_o));  // R10
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_o == 3'd0 && gates_off_o));  // R11
endmodule

bind ocp_retry_seq ocp_retry_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .sw_tick_i    (sw_tick_i),
    .oc_det_i     (oc_det_i),
    .open_sense_i (open_sense_i),
    .ss_done_i    (ss_done_i),
    .ss_start_o   (ss_start_o),
    .gates_off_o  (gates_off_o),
    .running_o    (running_o),
    .state_o      (state_o)
);

// File: tb/ocp_retry_seq_test.sv
// Self-checking bench: sweeps every state against all input combinations,
// then times hiccup waits with irregular tick spacing.
module ocp_retry_seq_test;
    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, tick = 1'b0, oc = 1'b0, opn = 1'b0, ssd = 1'b0;
    logic       ss_start, gates_off, running;
    logic [2:0] state;
    int         n_checks = 0;
    int         n_err = 0;
    int         cyc = 0;

    always #10 clk = ~clk;  // 50 MHz

    ocp_retry_seq #(.WAIT_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .sw_tick_i(tick), .oc_det_i(oc),
        .open_sense_i(opn), .ss_done_i(ssd), .ss_start_o(ss_start),
        .gates_off_o(gates_off), .running_o(running), .state_o(state)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check all outputs against an expected state and pulse value.
    task automatic chk_all(input string req, input int s_exp, input int ss_exp);
        chk({req, " state"}, int'(state), s_exp);
        chk({req, " R2 gates_off"}, int'(gates_off), (s_exp == 0 || s_exp == 3 || s_exp == 4) ? 1 : 0);
        chk({req, " R2 running"}, int'(running), (s_exp == 2) ? 1 : 0);
        chk({req, " ss_start"}, int'(ss_start), ss_exp);
    endtask

    // Drive inputs at a falling edge and return at the next falling edge.
    task automatic step(input logic e, input logic t, input logic o, input logic p, input logic d);
        en = e; tick = t; oc = o; opn = p; ssd = d;
        @(negedge clk);
    endtask

    task automatic goto_state(input int s);
        step(0, 0, 0, 0, 0);
        if (s == 4) step(1, 0, 0, 1, 0);
        if (s >= 1 && s <= 3) step(1, 0, 0, 0, 0);
        if (s == 2 || s == 3) step(1, 0, 0, 0, 1);
        if (s == 3) step(1, 0, 1, 0, 0);
    endtask

    // Expected next state from the priority rules (wait count assumed not complete).
    function automatic int exp_next(input int s, input logic e, input logic o,
                                    input logic p, input logic d);
        if (!e) return 0;
        if (p) return 4;
        case (s)
            0: return 1;
            1: return o ? 3 : (d ? 2 : 1);
            2: return o ? 3 : 2;
            3: return 3;
            default: return 1;
        endcase
    endfunction

    initial begin
        @(negedge clk);
        chk_all("R1 in reset", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 after reset", 0, 0);

        // Exhaustive state x input sweep (R3 R4 R5 R7 R9 R10 R11).
        for (int s = 0; s < 5; s++) begin
            for (int v = 0; v < 32; v++) begin
                logic e, t, o, p, d;
                int   nx;
                e = v[0]; t = v[1]; o = v[2]; p = v[3]; d = v[4];
                goto_state(s);
                nx = exp_next(s, e, o, p, d);
                step(e, t, o, p, d);
                chk_all($sformatf("R3/R4/R5/R9/R10/R11 sweep s=%0d v=%0d", s, v),
                        nx, (nx == 1 && s != 1) ? 1 : 0);
            end
        end

        // R6 and R7: wait length with irregular gaps and overcurrent held on some cycles.
        goto_state(2);
        step(1, 1, 1, 0, 0);
        chk_all("R6 trip, tick not counted", 3, 0);
        for (int k = 1; k <= W; k++) begin
            for (int g = 0; g < k % 3; g++) begin
                step(1, 0, k[0], 0, 0);
                chk_all("R7 idle gap in wait", 3, 0);
            end
            step(1, 1, k[0], 0, 0);
            if (k < W) chk_all("R6 wait not done", 3, 0);
            else       chk_all("R6 wait ends on last tick", 1, 1);
        end
        // R8: fault persists into retry.
        step(1, 0, 1, 0, 0);
        chk_all("R8 retrip", 3, 0);
        for (int k = 0; k < W; k++) step(1, 1, 1, 0, 0);
        chk_all("R8 second retry", 1, 1);
        step(1, 0, 1, 0, 0);
        chk_all("R8 retrip again", 3, 0);

        // R11: partial wait, disable, full wait again.
        for (int k = 0; k < W - 1; k++) step(1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk_all("R11 disable from wait", 0, 0);
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1);
        step(1, 0, 1, 0, 0);
        for (int k = 0; k < W - 1; k++) step(1, 1, 0, 0, 0);
        chk_all("R11 count cleared", 3, 0);
        step(1, 1, 0, 0, 0);
        chk_all("R11 full wait", 1, 1);
        step(1, 0, 0, 0, 0);
        chk_all("R3 pulse one clock", 1, 0);

        // R9 and R10: open-sense on the last wait tick wins, hold, then release.
        step(1, 0, 1, 0, 0);
        for (int k = 0; k < W - 1; k++) step(1, 1, 0, 0, 0);
        step(1, 1, 0, 1, 0);
        chk_all("R9 open beats wait end", 4, 0);
        for (int k = 0; k < 3; k++) begin
            step(1, 1, 1, 1, 1);
            chk_all("R9 held in shutdown", 4, 0);
        end
        step(1, 0, 0, 0, 0);
        chk_all("R10 restart soft-start", 1, 1);
        step(1, 0, 1, 0, 1);
        chk_all("R5 oc beats ss_done", 3, 0);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end
endmodule